// File: doc/BRIEF.md
# Debounced Input Change Detector

This block watches six general-purpose input pins and reports when their levels change. Each pin first passes through a two-flop synchroniser. The synchronised value is then sampled on a slow sample tick. The tick is made by counting pulses of a reference clock enable, and it fires once every `TICK_DIV` pulses (96 by default, which turns a 3.6864 MHz enable rate into a 38.4 kHz tick).

A new level is taken only when two consecutive ticks see the same value. The accepted level is therefore stable and free of glitches. A level held for two tick periods is always caught. A level that arrives just before a tick can be caught after a single period. Whenever an accepted level differs from the one before it, the block sets a sticky delta bit for that pin and raises an aggregate change flag.

A bus read strobe returns a byte-wide change register. Reading it clears every delta bit and the change flag. Interrupt masking belongs to the surrounding logic. This block only drives the raw flag.

Top module: `pin_change_detect`

## Requirements
- R1: While `rst` is high on a clock edge, `levels`, `deltas`, `chg_irq` and `chg_reg` all become zero.
- R2: The sample tick fires once for every `TICK_DIV` cycles in which `ref_en` is high. While `ref_en` stays low, no tick fires and no accepted level changes, whatever the pins do.
- R3: The first tick after reset loads the accepted levels from the synchronised pins and raises no delta bit.
- R4: A pin value seen on only one tick, with a different value on the ticks either side, is ignored. The accepted level and the delta bit of that pin stay unchanged.
- R5: A pin value that differs from the accepted level and is held across two consecutive ticks becomes the accepted level. It appears on `levels` in the cycle after the second tick.
- R6: When a new level is accepted, the pin's delta bit is set in the same cycle. The bit stays set until a read, even if the pin later returns to its former level.
- R7: `chg_reg` bit 4+i holds the delta bit of pin i, and bit i holds the accepted level of pin i, for i = 0 to 3. Pins 4 and 5 appear only on `levels` and `deltas`.
- R8: A clock edge with `rd_stb` high clears all six delta bits and `chg_irq`. A delta bit being set on that same edge survives the clear.
- R9: `chg_irq` is high exactly when at least one delta bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | Reference clock enable, one pulse per reference period |
| pins_in | input | NUM_PINS | Asynchronous general-purpose inputs |
| rd_stb | input | 1 | Change register read strobe, one cycle per read |
| chg_reg | output | 8 | Change register: delta bits of pins 3..0 above, levels of pins 3..0 below |
| levels | output | NUM_PINS | Accepted (filtered) pin levels |
| deltas | output | NUM_PINS | Sticky per-pin change bits |
| chg_irq | output | 1 | Aggregate change flag |

## Verification
The assertions take `ref_en` and `rd_stb` to be synchronous to `clk`. `pins_in` may be asynchronous, because only the synchroniser sees it. The bench drives every input on the falling edge, so each input is steady at the rising edge where it is sampled. It changes the pins roughly 40 cycles after a consumed tick, far enough from the next one that the two synchroniser stages have settled. That placement makes the tick on which a value is first seen known in advance. It also lets a one-tick pulse land on exactly one sample.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  localparam int REG_W = 8;
  localparam int NIB_W = REG_W / 2;

  // upper half: change bits, lower half: levels, pin i at position i of each half
  function automatic logic [REG_W-1:0] pack_chg(input logic [NIB_W-1:0] dlt,
                                                input logic [NIB_W-1:0] lvl);
    return {dlt, lvl};
  endfunction
endpackage

// File: rtl/pcd_tick_gen.sv
module pcd_tick_gen #(
  parameter int TICK_DIV = 96
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_en,
  output logic smp_tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] div_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt  <= '0;
      smp_tick <= 1'b0;
    end else begin
      smp_tick <= ref_en && (div_cnt == LAST);
      if (ref_en) begin
        div_cnt <= (div_cnt == LAST) ? '0 : div_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcd_sync2.sv
module pcd_sync2 #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      d_sync <= '0;
    end else begin
      stage1 <= d_async;
      d_sync <= stage1;
    end
  end
endmodule

// File: rtl/pcd_pin_filter.sv
module pcd_pin_filter (
  input  logic clk,
  input  logic rst,
  input  logic smp_tick,
  input  logic smp,
  input  logic clr,
  output logic level,
  output logic delta,
  output logic set_pulse
);
  logic primed;
  logic prev_smp;

  // accept only when this tick agrees with the previous one and differs from the held level
  assign set_pulse = smp_tick && primed && (smp == prev_smp) && (smp != level);

  always_ff @(posedge clk) begin
    if (rst) begin
      primed   <= 1'b0;
      prev_smp <= 1'b0;
      level    <= 1'b0;
      delta    <= 1'b0;
    end else begin
      if (smp_tick) begin
        prev_smp <= smp;
        if (!primed) begin
          primed <= 1'b1;
          level  <= smp;
        end else if (set_pulse) begin
          level <= smp;
        end
      end
      if (set_pulse) begin
        delta <= 1'b1;
      end else if (clr) begin
        delta <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pin_change_detect.sv
module pin_change_detect
  import pcd_pkg::*;
#(
  parameter int NUM_PINS = 6,
  parameter int TICK_DIV = 96
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ref_en,
  input  logic [NUM_PINS-1:0] pins_in,
  input  logic                rd_stb,
  output logic [REG_W-1:0]    chg_reg,
  output logic [NUM_PINS-1:0] levels,
  output logic [NUM_PINS-1:0] deltas,
  output logic                chg_irq
);
  logic                smp_tick;
  logic [NUM_PINS-1:0] pins_sync;
  logic [NUM_PINS-1:0] set_vec;

  pcd_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .ref_en(ref_en), .smp_tick(smp_tick)
  );

  pcd_sync2 #(.W(NUM_PINS)) u_sync (
    .clk(clk), .rst(rst), .d_async(pins_in), .d_sync(pins_sync)
  );

  for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin
    pcd_pin_filter u_filt (
      .clk(clk), .rst(rst), .smp_tick(smp_tick), .smp(pins_sync[gi]),
      .clr(rd_stb), .level(levels[gi]), .delta(deltas[gi]),
      .set_pulse(set_vec[gi])
    );
  end

  // flag kept in its own register: a fresh change outranks a read
  always_ff @(posedge clk) begin
    if (rst) chg_irq <= 1'b0;
    else     chg_irq <= (|set_vec) || (chg_irq && !rd_stb);
  end

  assign chg_reg = pack_chg(deltas[NIB_W-1:0], levels[NIB_W-1:0]);
endmodule

// File: rtl/pin_change_detect_chk.sv
module pin_change_detect_chk #(
  parameter int NUM_PINS = 6
) (
  input logic                clk,
  input logic                rst,
  input logic                ref_en,
  input logic                smp_tick,
  input logic                rd_stb,
  input logic [NUM_PINS-1:0] levels,
  input logic [NUM_PINS-1:0] deltas,
  input logic                chg_irq
);
  // R2
  tick_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    smp_tick |-> $past(ref_en));

  // R2
  tick_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    smp_tick |=> !smp_tick);

  // R4
  levels_hold_between_ticks_chk: assert property (@(posedge clk) disable iff (rst)
    !smp_tick |=> $stable(levels));

  // R6
  delta_only_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !smp_tick |=> ((deltas & ~$past(deltas)) == '0));

  // R6
  delta_needs_level_move_chk: assert property (@(posedge clk) disable iff (rst)
    ((deltas & ~$past(deltas)) & ~(levels ^ $past(levels))) == '0);

  // R8
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !smp_tick) |=> (deltas == '0 && !chg_irq));

  // R9
  irq_tracks_deltas_chk: assert property (@(posedge clk) disable iff (rst)
    chg_irq == (|deltas));
endmodule

bind pin_change_detect pin_change_detect_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst(rst), .ref_en(ref_en), .smp_tick(smp_tick), .rd_stb(rd_stb),
  .levels(levels), .deltas(deltas), .chg_irq(chg_irq)
);

// File: tb/pin_change_detect_bench.sv
`timescale 1ns/1ps
module pin_change_detect_bench;
  localparam int NP  = 6;
  localparam int DIV = 96;
  localparam int NV  = 11;

  logic          clk = 1'b0;
  logic          rst;
  logic          ref_en;
  logic [NP-1:0] pins_in;
  logic          rd_stb;
  logic [7:0]    chg_reg;
  logic [NP-1:0] levels;
  logic [NP-1:0] deltas;
  logic          chg_irq;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  int wd     = 0;

  always #5 clk = ~clk;

  pin_change_detect #(.NUM_PINS(NP), .TICK_DIV(DIV)) u_pin_change_detect (
    .clk(clk), .rst(rst), .ref_en(ref_en), .pins_in(pins_in), .rd_stb(rd_stb),
    .chg_reg(chg_reg), .levels(levels), .deltas(deltas), .chg_irq(chg_irq)
  );

  // edges since reset release; a tick is consumed on edges where cyc becomes 1 mod DIV
  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd == 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: act=%0d cycles exp<150000", wd);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  // fields: pins[20:15] periods[14:13] levels[12:7] deltas[6:1] read[0]
  localparam logic [20:0] VEC [NV] = '{
    {6'b101011, 2'd1, 6'b101010, 6'b000000, 1'b0},  // R4 seen once
    {6'b101011, 2'd1, 6'b101011, 6'b000001, 1'b1},  // R5 R7
    {6'b010101, 2'd2, 6'b010101, 6'b111110, 1'b0},  // R5 R6
    {6'b010100, 2'd2, 6'b010100, 6'b111111, 1'b1},  // R6 sticky, R7
    {6'b110100, 2'd1, 6'b010100, 6'b000000, 1'b0},  // R4 glitch on pin 5, R8 cleared all
    {6'b010100, 2'd2, 6'b010100, 6'b000000, 1'b0},  // R4 glitch rejected
    {6'b011100, 2'd1, 6'b010100, 6'b000000, 1'b0},  // R4 alternating
    {6'b010100, 2'd1, 6'b010100, 6'b000000, 1'b0},  // R4
    {6'b011100, 2'd1, 6'b010100, 6'b000000, 1'b0},  // R4
    {6'b011100, 2'd1, 6'b011100, 6'b001000, 1'b1},  // R5 R7
    {6'b010100, 2'd2, 6'b010100, 6'b001000, 1'b0}   // R6 flagged after return
  };

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: act=%b exp=%b", what, act, exp);
    end
  endtask

  task automatic goto(input int off);
    @(negedge clk);
    while ((cyc % DIV) != off) @(negedge clk);
  endtask

  task automatic pulse_read();
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  initial begin
    rst = 1'b1; ref_en = 1'b1; rd_stb = 1'b0; pins_in = 6'b101010;
    repeat (3) @(negedge clk);
    chk("R1 reset levels", 8'(levels), 8'h00);
    chk("R1 reset deltas", 8'(deltas), 8'h00);
    chk("R1 reset irq", 8'(chg_irq), 8'h00);
    chk("R1 reset chg_reg", chg_reg, 8'h00);
    rst = 1'b0;

    // R3: first consumed tick primes without a delta
    while (cyc != DIV + 1) @(negedge clk);
    chk("R3 prime levels", 8'(levels), 8'(6'b101010));
    chk("R3 prime deltas", 8'(deltas), 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [5:0] exp_l, exp_d;
      exp_l = VEC[i][12:7];
      exp_d = VEC[i][6:1];
      goto(41);
      pins_in = VEC[i][20:15];
      for (int p = 0; p < int'(VEC[i][14:13]); p++) goto(1);
      chk($sformatf("R4/R5 vec%0d levels", i), 8'(levels), 8'(exp_l));
      chk($sformatf("R6 vec%0d deltas", i), 8'(deltas), 8'(exp_d));
      chk($sformatf("R9 vec%0d irq", i), 8'(chg_irq), 8'(|exp_d));
      if (VEC[i][0]) begin
        chk($sformatf("R7 vec%0d chg_reg", i), chg_reg, {exp_d[3:0], exp_l[3:0]});
        pulse_read();
        chk($sformatf("R8 vec%0d cleared", i), {1'b0, chg_irq, deltas}, 8'h00);
      end
    end

    // R8: read on the same edge as a new acceptance; the new bit survives
    goto(41);
    pins_in = 6'b010110;
    goto(1);
    goto(0);
    pulse_read();
    chk("R8 collision deltas", 8'(deltas), 8'(6'b000010));
    chk("R8 collision irq", 8'(chg_irq), 8'h01);
    chk("R7 collision chg_reg", chg_reg, 8'b0010_0110);
    pulse_read();
    chk("R8 plain read", {1'b0, chg_irq, deltas}, 8'h00);
    chk("R7 after read chg_reg", chg_reg, 8'b0000_0110);

    // R2: no enable, no ticks, no acceptance
    ref_en = 1'b0;
    pins_in = 6'b000000;
    repeat (400) @(negedge clk);
    chk("R2 frozen levels", 8'(levels), 8'(6'b010110));
    chk("R2 frozen deltas", 8'(deltas), 8'h00);
    ref_en = 1'b1;
    repeat (300) @(negedge clk);
    chk("R2 resumed levels", 8'(levels), 8'h00);
    chk("R2 resumed deltas", 8'(deltas), 8'(6'b010110));

    // R1 and R3 again from a busy state
    rst = 1'b1;
    pins_in = 6'b111111;
    repeat (2) @(negedge clk);
    chk("R1 mid reset state", {chg_irq, 1'b0, deltas}, 8'h00);
    chk("R1 mid reset chg_reg", chg_reg, 8'h00);
    rst = 1'b0;
    repeat (250) @(negedge clk);
    chk("R3 reprime levels", 8'(levels), 8'(6'b111111));
    chk("R3 reprime deltas", 8'(deltas), 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule